// File: doc/BRIEF.md
# Iterative DES Round Engine

This block enciphers or deciphers a single 64-bit block with the Data Encryption Standard. It uses one folded Feistel stage that finishes one round on every clock edge. The block does not generate round keys. A separate key-schedule block drives the 48-bit round key for each round on the `round_key` input, and cycle timing alone decides which round key belongs to which round. Decryption runs on the same hardware. The key schedule only has to present the sixteen round keys in reverse order.

The eight substitution tables are synchronous-read ROMs. Each ROM is dual-ported and holds two tables, so four ROMs cover all eight. Each lookup result appears one edge after its address, so the S-box output register is the round register. Each cycle, the next S-box address comes straight from the previous lookup. The path runs through the P permutation, the XOR with the left half, the expansion and the key XOR.

A three-state controller sequences the work. In `ST_IDLE`, a `load` pulse moves it to `ST_ROUNDS`. It stays in `ST_ROUNDS` for fifteen edges while the round count steps up. At count 15 it moves to `ST_LAST`. From `ST_LAST` it always returns to `ST_IDLE`, and on that edge the final output is written.

Top module: `des_iter_core`

## Requirements
- R1: When `load` is high on a rising edge while idle, `block_in` is captured. The initial permutation is applied, bits 63:32 of the result become L0 and bits 31:0 become R0.
- R2: `round_key` is sampled as the round-1 key on the capturing edge. On each of the next 15 edges it is sampled as the key for rounds 2 to 16.
- R3: `done` is high for exactly one cycle, starting at the 16th rising edge after the capturing edge.
- R4: With round keys K1..K16 in forward order, `block_out` is standard DES encryption: the final permutation is applied to R16 concatenated with L16.
- R5: With the same keys in reverse order, the block performs decryption and returns the original plaintext.
- R6: The 48-bit key-mixed value is split into eight 6-bit groups, with group 1 in bits 47:42. Each group addresses its own table, with row {bit5,bit0} and column bits 4:1, and the table outputs are joined with table 1 in bits 31:28.
- R7: A `load` that arrives while a block is in progress is ignored. It changes neither the result nor its timing.
- R8: `block_out` holds its value between `done` pulses.
- R9: A `load` in the cycle where `done` is high is accepted, so blocks can run back to back every 17 cycles.
- R10: After synchronous reset (`rst` high), the block is idle, `done` is low and `block_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Start strobe, accepted only when idle |
| block_in | input | 64 | Plaintext or ciphertext block |
| round_key | input | 48 | Round key for the round being computed this cycle |
| block_out | output | 64 | Result block, held until the next result |
| done | output | 1 | One-cycle pulse when `block_out` is new |

## Verification
The result and `done` are due on the 16th edge after the capturing edge. The bench samples on falling edges and counts its way through a block: it checks that `done` is still low after edge 15 and that it is high, with the expected block, after edge 16. Round keys are changed on the falling edge before each round's edge, and the expected outputs come from published known-answer pairs. A checker counter inside the controller confirms the same 16-edge latency on every pulse.

// File: rtl/des_pkg.sv
package des_pkg;

    localparam int BLK_W    = 64;
    localparam int HALF_W   = BLK_W / 2;
    localparam int KEY_W    = 48;
    localparam int SB_IN    = 6;
    localparam int SB_OUT   = 4;
    localparam int NUM_SBOX = KEY_W / SB_IN;
    localparam int NUM_ROM  = NUM_SBOX / 2;
    localparam int SB_DEPTH = 1 << SB_IN;
    localparam int TAB_W    = SB_DEPTH * SB_OUT;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROUNDS,
        ST_LAST
    } round_state_t;

    // Each table: entry (row*16 + col) sits in nibble e counted from the MSB.
    localparam logic [TAB_W-1:0] SBOX_TAB [NUM_SBOX] = '{
        256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
        256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
        256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
        256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
        256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
        256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
        256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
        256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
    };

    localparam int P_TAB [HALF_W] = '{
        16,  7, 20, 21, 29, 12, 28, 17,  1, 15, 23, 26,  5, 18, 31, 10,
         2,  8, 24, 14, 32, 27,  3,  9, 19, 13, 30,  6, 22, 11,  4, 25
    };

    // Source bit (1 = MSB) feeding output bit i of the initial permutation.
    function automatic int ip_src(input int i);
        int r;
        int c;
        r = (i - 1) / 8;
        c = (i - 1) % 8;
        if (r < 4) return 58 + 2 * r - 8 * c;
        return 57 + 2 * (r - 4) - 8 * c;
    endfunction

    function automatic logic [BLK_W-1:0] init_perm(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] o;
        o = '0;
        for (int i = 1; i <= BLK_W; i++) o[BLK_W-i] = x[BLK_W-ip_src(i)];
        return o;
    endfunction

    function automatic logic [BLK_W-1:0] final_perm(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] o;
        o = '0;
        for (int i = 1; i <= BLK_W; i++) o[BLK_W-ip_src(i)] = x[BLK_W-i];
        return o;
    endfunction

    function automatic logic [KEY_W-1:0] expand(input logic [HALF_W-1:0] x);
        logic [KEY_W-1:0] o;
        int s;
        o = '0;
        for (int j = 1; j <= KEY_W; j++) begin
            s = 4 * ((j - 1) / SB_IN) + ((j - 1) % SB_IN);
            if (s == 0) s = HALF_W;
            if (s > HALF_W) s = 1;
            o[KEY_W-j] = x[HALF_W-s];
        end
        return o;
    endfunction

    function automatic logic [HALF_W-1:0] p_perm(input logic [HALF_W-1:0] x);
        logic [HALF_W-1:0] o;
        o = '0;
        for (int i = 1; i <= HALF_W; i++) o[HALF_W-i] = x[HALF_W-P_TAB[i-1]];
        return o;
    endfunction

    function automatic logic [SB_OUT-1:0] sbox_val(input int idx, input logic [SB_IN-1:0] a);
        int e;
        e = 16 * int'({a[5], a[0]}) + int'(a[4:1]);
        return SBOX_TAB[idx][TAB_W-1-SB_OUT*e -: SB_OUT];
    endfunction

endpackage

// File: rtl/des_sbox_rom.sv
module des_sbox_rom
    import des_pkg::*;
#(
    parameter int FIRST = 0
) (
    input  logic              clk,
    input  logic              en,
    input  logic [SB_IN-1:0]  addr_a,
    input  logic [SB_IN-1:0]  addr_b,
    output logic [SB_OUT-1:0] q_a,
    output logic [SB_OUT-1:0] q_b
);

    // Two tables per ROM, one per port; outputs are registered.
    always_ff @(posedge clk) begin
        if (en) begin
            q_a <= sbox_val(FIRST, addr_a);
            q_b <= sbox_val(FIRST + 1, addr_b);
        end
    end

endmodule

// File: rtl/des_round_ctrl.sv
module des_round_ctrl
    import des_pkg::*;
#(
    parameter int ROUNDS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic capture,
    output logic advance,
    output logic finish,
    output logic done
);

    localparam int CNT_W = $clog2(ROUNDS + 1);
    localparam int LAT_W = $clog2(ROUNDS + 3);

    round_state_t           state;
    logic [CNT_W-1:0]       cnt;

    // State register process.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (load) begin
                        state <= ST_ROUNDS;
                        cnt   <= CNT_W'(1);
                    end
                end
                ST_ROUNDS: begin
                    if (cnt == CNT_W'(ROUNDS - 1)) state <= ST_LAST;
                    else                           cnt   <= cnt + 1'b1;
                end
                ST_LAST: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output process.
    always_comb begin
        capture = 1'b0;
        advance = 1'b0;
        finish  = 1'b0;
        unique case (state)
            ST_IDLE:   capture = load;
            ST_ROUNDS: advance = 1'b1;
            ST_LAST:   finish  = 1'b1;
            default:   capture = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= finish;
    end

    // Checker counter: edges since the capturing edge, saturating.
    logic [LAT_W-1:0] lat;
    always_ff @(posedge clk) begin
        if (rst)                          lat <= '0;
        else if (capture)                 lat <= LAT_W'(1);
        else if (lat != '0 && lat != LAT_W'(ROUNDS + 2)) lat <= lat + 1'b1;
    end

    // R3: done appears exactly ROUNDS edges after capture
    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> lat == LAT_W'(ROUNDS + 1));

    // R3: done is a single-cycle pulse
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: round count stays inside the key window while rounds run
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
        state == ST_ROUNDS |-> (cnt >= CNT_W'(1) && cnt <= CNT_W'(ROUNDS - 1)));

    // R9: controller is idle, ready for a new block, whenever done is high
    a_r9_idle_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> state == ST_IDLE);

endmodule

// File: rtl/des_feistel_dp.sv
module des_feistel_dp
    import des_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             advance,
    input  logic             finish,
    input  logic [BLK_W-1:0] block_in,
    input  logic [KEY_W-1:0] round_key,
    output logic [BLK_W-1:0] block_out
);

    logic [HALF_W-1:0] half_a;     // left half of the previous round
    logic [HALF_W-1:0] half_b;     // right half of the previous round
    logic [BLK_W-1:0]  ip_val;
    logic [HALF_W-1:0] sbx;        // registered S-box outputs (round register)
    logic [HALF_W-1:0] r_next;
    logic [HALF_W-1:0] r_src;
    logic [KEY_W-1:0]  mix;
    logic [SB_OUT-1:0] nib [NUM_SBOX];
    logic              rom_en;

    assign ip_val = init_perm(block_in);
    assign r_next = half_a ^ p_perm(sbx);
    assign r_src  = capture ? ip_val[HALF_W-1:0] : r_next;
    assign mix    = expand(r_src) ^ round_key;
    assign rom_en = capture | advance;

    generate
        for (genvar p = 0; p < NUM_ROM; p++) begin : g_rom
            des_sbox_rom #(.FIRST(2 * p)) u_rom (
                .clk    (clk),
                .en     (rom_en),
                .addr_a (mix[KEY_W-1-2*SB_IN*p -: SB_IN]),
                .addr_b (mix[KEY_W-1-SB_IN-2*SB_IN*p -: SB_IN]),
                .q_a    (nib[2*p]),
                .q_b    (nib[2*p+1])
            );
        end
    endgenerate

    always_comb begin
        for (int g = 0; g < NUM_SBOX; g++) sbx[HALF_W-1-SB_OUT*g -: SB_OUT] = nib[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_a    <= '0;
            half_b    <= '0;
            block_out <= '0;
        end else begin
            if (capture) begin
                half_a <= ip_val[BLK_W-1:HALF_W];
                half_b <= ip_val[HALF_W-1:0];
            end else if (advance) begin
                half_a <= half_b;
                half_b <= r_next;
            end
            if (finish) block_out <= final_perm({r_next, half_b});
        end
    end

endmodule

// File: rtl/des_iter_core.sv
module des_iter_core
    import des_pkg::*;
#(
    parameter int ROUNDS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [BLK_W-1:0] block_in,
    input  logic [KEY_W-1:0] round_key,
    output logic [BLK_W-1:0] block_out,
    output logic             done
);

    logic capture;
    logic advance;
    logic finish;

    des_round_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .capture (capture),
        .advance (advance),
        .finish  (finish),
        .done    (done)
    );

    des_feistel_dp u_dp (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .advance   (advance),
        .finish    (finish),
        .block_in  (block_in),
        .round_key (round_key),
        .block_out (block_out)
    );

    // R8: the result only moves together with a done pulse
    a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(block_out));

endmodule

// File: tb/sim_des_iter_core.sv
`timescale 1ns/1ps
module sim_des_iter_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [63:0] din = '0;
    logic [47:0] skey = '0;
    logic [63:0] dout;
    logic        done;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    des_iter_core u0 (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .block_in  (din),
        .round_key (skey),
        .block_out (dout),
        .done      (done)
    );

    localparam int PC1 [56] = '{
        57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
    };
    localparam int PC2 [48] = '{
        14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
    };
    localparam int SHIFTS [16] = '{1, 1, 2, 2, 2, 2, 2, 2, 1, 2, 2, 2, 2, 2, 2, 1};

    logic [47:0] ks [16];

    task automatic make_keys(input logic [63:0] key, input bit dec);
        logic [55:0] cd;
        logic [27:0] c;
        logic [27:0] d;
        logic [47:0] k;
        for (int i = 1; i <= 56; i++) cd[56-i] = key[64-PC1[i-1]];
        c = cd[55:28];
        d = cd[27:0];
        for (int r = 0; r < 16; r++) begin
            for (int s = 0; s < SHIFTS[r]; s++) begin
                c = {c[26:0], c[27]};
                d = {d[26:0], d[27]};
            end
            cd = {c, d};
            for (int i = 1; i <= 48; i++) k[48-i] = cd[56-PC2[i-1]];
            if (dec) ks[15-r] = k;
            else     ks[r]    = k;
        end
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Starts at a falling edge; ends at the falling edge where done is high.
    task automatic run_block(input string req, input logic [63:0] blk, input logic [63:0] key,
                             input bit dec, input logic [63:0] exp, input bit poke);
        make_keys(key, dec);
        load = 1'b1;
        din  = blk;
        skey = ks[0];
        for (int i = 1; i < 16; i++) begin
            @(negedge clk);
            load = poke && (i == 6);        // R7: stray load while busy
            din  = poke ? ~blk : blk;
            skey = ks[i];
        end
        @(negedge clk);
        load = 1'b0;
        skey = '0;
        chk("R3 done low after edge 15", {63'd0, done}, 64'd0);
        @(negedge clk);
        chk("R3 done high after edge 16", {63'd0, done}, 64'd1);
        chk(req, dout, exp);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 done at reset", {63'd0, done}, 64'd0);
        chk("R10 result at reset", dout, 64'd0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_encrypt;
        run_block("R4 R1 R2 R6 encrypt vector A", 64'h0123456789ABCDEF,
                  64'h133457799BBCDFF1, 1'b0, 64'h85E813540F0AB405, 1'b0);
        @(negedge clk);
        run_block("R4 R6 encrypt all-zero", 64'h0, 64'h0, 1'b0, 64'h8CA64DE9C1B123A7, 1'b0);
        @(negedge clk);
        run_block("R4 R6 encrypt all-one", 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF,
                  1'b0, 64'h7359B2163E4EDC58, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_decrypt;
        run_block("R5 decrypt vector A", 64'h85E813540F0AB405, 64'h133457799BBCDFF1,
                  1'b1, 64'h0123456789ABCDEF, 1'b0);
        @(negedge clk);
        run_block("R5 decrypt to repeated pattern", 64'h0000000000000000, 64'h0E329232EA6D0D73,
                  1'b1, 64'h8787878787878787, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_busy_load;
        run_block("R7 busy load ignored", 64'h8787878787878787, 64'h0E329232EA6D0D73,
                  1'b0, 64'h0000000000000000, 1'b1);
        @(negedge clk);
    endtask

    task automatic t_back_to_back;
        run_block("R9 first of pair", 64'h0123456789ABCDEF, 64'h133457799BBCDFF1,
                  1'b0, 64'h85E813540F0AB405, 1'b0);
        run_block("R9 second accepted at done", 64'h0, 64'h0, 1'b0, 64'h8CA64DE9C1B123A7, 1'b0);
    endtask

    task automatic t_hold;
        logic [63:0] kept;
        kept = dout;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R8 result held", dout, kept);
            chk("R3 done stays low", {63'd0, done}, 64'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_encrypt();
        t_decrypt();
        t_busy_load();
        t_back_to_back();
        t_hold();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule